// File: doc/BRIEF.md
# Two-Stage APB Watchdog Timer

This peripheral watches for software that has stopped making progress. A down-counter, advanced by a separate tick-enable input, runs from a programmable reload value. The first time the count runs out, the block raises an interrupt and starts counting again from the reload value. If software has not cleared that interrupt by the time the count runs out a second time, the block raises a sticky reset request and stops counting. Either output can be enabled or masked on its own.

Software reaches the block through an APB slave port. Through that port it can set the reload value, read the live count, set the two enables, acknowledge the interrupt, and read the raw and masked interrupt state. A key register guards every other register against stray writes. A test mode lets two register bits drive the interrupt and reset pins directly, so the wiring around the block can be checked. The port always completes an access in one access phase and never signals an error.

Top module: `apb_wdt`

## Requirements
- R1: After reset, the reload value and the count are both 0xFFFFFFFF and the counter is running. The control, raw status, lock and test-control registers read zero, and both outputs are low.
- R2: In each clock cycle with `tick_en` high, a running counter with a non-zero count drops by exactly one. With `tick_en` low the count holds.
- R3: A tick that finds the count at zero while the raw interrupt flag is clear sets the flag (bit 0 of offset 0x10) and reloads the count from the reload value.
- R4: A tick that finds the count at zero while the raw flag is already set raises a sticky reset status and stops the counter. The count then stays at zero and the status stays set until the block is reset.
- R5: Control register offset 0x08 has the interrupt enable in bit 0 and the reset enable in bit 1, and its other bits read as zero. `wdt_irq` is the raw flag ANDed with bit 0. `wdt_rst` is the sticky reset status ANDed with bit 1. Offset 0x14 reads the raw flag ANDed with bit 0.
- R6: A write to offset 0x00 sets the reload value and the count to the written data and starts the counter, even after a stop.
- R7: Any write to offset 0x0C clears the raw flag and reloads the count from the reload value. It does not clear the sticky reset status.
- R8: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, and writing any other value locks it. Offset 0xC00 reads 1 while locked. While locked, writes to any other offset have no effect.
- R9: While bit 0 of offset 0xF00 is set, `wdt_rst` follows bit 0 and `wdt_irq` follows bit 1 of write-only offset 0xF04, whatever the functional state.
- R10: Reads of offsets 0x0C, 0xF04 and unmapped offsets return zero. Writes to 0x04, 0x10, 0x14 and unmapped offsets change nothing. `pready` is always 1 and `pslverr` always 0.
- R11: When a register write to offset 0x00 lands in the same cycle as a tick, the write wins, and the count equals the written value afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Asynchronous active-low reset, released in step with `pclk` inside the block |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Tied high |
| pslverr | output | 1 | Tied low |
| tick_en | input | 1 | Count-enable tick, synchronous to `pclk` |
| wdt_irq | output | 1 | Watchdog interrupt |
| wdt_rst | output | 1 | Watchdog reset request |

## Verification
The hardest state to reach from the ports is the second timeout. The count has to run out twice with the interrupt never serviced in between, and only then can the bench show that the count freezes at zero and that neither the interrupt clear nor the enable bits release the sticky reset. The bench gets there quickly by loading a small reload value, enabling both outputs, and issuing exact tick bursts. It also checks several things in that stopped state: that masking with the reset enable hides the output only while the bit is clear, and that a later load write restarts counting without clearing the reset. A further check holds a tick high in exactly the access cycle of a load write, which shows the write taking priority.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned BUS_W = 32;

  localparam logic [11:0] OFS_RELOAD = 12'h000;
  localparam logic [11:0] OFS_COUNT  = 12'h004;
  localparam logic [11:0] OFS_CTRL   = 12'h008;
  localparam logic [11:0] OFS_ACK    = 12'h00C;
  localparam logic [11:0] OFS_RAW    = 12'h010;
  localparam logic [11:0] OFS_MASKED = 12'h014;
  localparam logic [11:0] OFS_KEY    = 12'hC00;
  localparam logic [11:0] OFS_TMODE  = 12'hF00;
  localparam logic [11:0] OFS_TDRIVE = 12'hF04;

  localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

  // index of each output inside the two-bit output vectors
  localparam int unsigned OUT_RST = 0;
  localparam int unsigned OUT_IRQ = 1;
  localparam int unsigned N_OUT   = 2;

  typedef struct packed {
    logic reload_wr;
    logic ack_wr;
  } wdt_cmd_t;

endpackage

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  wdt_cmd_t         cmd,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             raw_o,
  output logic             rst_stat_o
);

  localparam logic [CNT_W-1:0] RELOAD_RST = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ZERO       = '0;

  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             run_q, run_d;
  logic             raw_q, raw_d;
  logic             rstat_q, rstat_d;
  logic             tick_live;

  assign tick_live = tick_en && run_q;

  // next state: register commands take priority over the tick
  always_comb begin
    count_d  = count_q;
    reload_d = reload_q;
    run_d    = run_q;
    raw_d    = raw_q;
    rstat_d  = rstat_q;
    if (cmd.reload_wr) begin
      reload_d = wdata;
      count_d  = wdata;
      run_d    = 1'b1;
    end else if (cmd.ack_wr) begin
      raw_d   = 1'b0;
      count_d = reload_q;
    end else if (tick_live) begin
      if (count_q != ZERO) begin
        count_d = count_q - 1'b1;
      end else if (!raw_q) begin
        raw_d   = 1'b1;
        count_d = reload_q;
      end else begin
        rstat_d = 1'b1;
        run_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= RELOAD_RST;
      reload_q <= RELOAD_RST;
      run_q    <= 1'b1;
      raw_q    <= 1'b0;
      rstat_q  <= 1'b0;
    end else begin
      count_q  <= count_d;
      reload_q <= reload_d;
      run_q    <= run_d;
      raw_q    <= raw_d;
      rstat_q  <= rstat_d;
    end
  end

  assign count_o    = count_q;
  assign reload_o   = reload_q;
  assign raw_o      = raw_q;
  assign rst_stat_o = rstat_q;

  assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_live && !cmd.reload_wr && !cmd.ack_wr && count_q != ZERO)
      |=> (count_q == $past(count_q) - 1'b1));

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cmd.reload_wr && !cmd.ack_wr) |=> $stable(count_q));

  assert_first_timeout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_live && !cmd.reload_wr && !cmd.ack_wr && count_q == ZERO && !raw_q)
      |=> (raw_q && count_q == $past(reload_q)));

  assert_sticky_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rstat_q |=> rstat_q);

  assert_frozen_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cmd.reload_wr && !cmd.ack_wr) |=> $stable(count_q));

  assert_reload_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.reload_wr |=> (run_q && count_q == $past(wdata) && reload_q == $past(wdata)));

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.ack_wr |=> (!raw_q && count_q == $past(reload_q)));

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CNT_W-1:0]  reload_i,
  input  logic              raw_i,
  output wdt_cmd_t          cmd_o,
  output logic [CNT_W-1:0]  wdata_o,
  output logic              irq_en_o,
  output logic              rst_en_o,
  output logic              tmode_o,
  output logic [N_OUT-1:0]  tdrive_o
);

  logic hit_reload, hit_count, hit_ctrl, hit_ack, hit_raw;
  logic hit_masked, hit_key, hit_tmode, hit_tdrive;
  logic wr_access, wr_open;

  logic             irq_en_q, irq_en_d;
  logic             rst_en_q, rst_en_d;
  logic             lock_q, lock_d;
  logic             tmode_q, tmode_d;
  logic [N_OUT-1:0] tdrive_q, tdrive_d;

  assign hit_reload = (paddr == ADDR_W'(OFS_RELOAD));
  assign hit_count  = (paddr == ADDR_W'(OFS_COUNT));
  assign hit_ctrl   = (paddr == ADDR_W'(OFS_CTRL));
  assign hit_ack    = (paddr == ADDR_W'(OFS_ACK));
  assign hit_raw    = (paddr == ADDR_W'(OFS_RAW));
  assign hit_masked = (paddr == ADDR_W'(OFS_MASKED));
  assign hit_key    = (paddr == ADDR_W'(OFS_KEY));
  assign hit_tmode  = (paddr == ADDR_W'(OFS_TMODE));
  assign hit_tdrive = (paddr == ADDR_W'(OFS_TDRIVE));

  assign wr_access = psel && penable && pwrite;
  assign wr_open   = wr_access && !lock_q;

  assign cmd_o.reload_wr = wr_open && hit_reload;
  assign cmd_o.ack_wr    = wr_open && hit_ack;
  assign wdata_o         = pwdata[CNT_W-1:0];

  always_comb begin
    irq_en_d = irq_en_q;
    rst_en_d = rst_en_q;
    lock_d   = lock_q;
    tmode_d  = tmode_q;
    tdrive_d = tdrive_q;
    if (wr_access && hit_key) begin
      lock_d = (pwdata != UNLOCK_KEY);
    end
    if (wr_open && hit_ctrl) begin
      irq_en_d = pwdata[0];
      rst_en_d = pwdata[1];
    end
    if (wr_open && hit_tmode) begin
      tmode_d = pwdata[0];
    end
    if (wr_open && hit_tdrive) begin
      tdrive_d = pwdata[N_OUT-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
      rst_en_q <= 1'b0;
      lock_q   <= 1'b0;
      tmode_q  <= 1'b0;
      tdrive_q <= '0;
    end else begin
      irq_en_q <= irq_en_d;
      rst_en_q <= rst_en_d;
      lock_q   <= lock_d;
      tmode_q  <= tmode_d;
      tdrive_q <= tdrive_d;
    end
  end

  // read mux: write-only and unmapped offsets fall through to zero
  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      unique case (1'b1)
        hit_reload: prdata = BUS_W'(reload_i);
        hit_count:  prdata = BUS_W'(count_i);
        hit_ctrl:   prdata = {{(BUS_W-2){1'b0}}, rst_en_q, irq_en_q};
        hit_raw:    prdata = {{(BUS_W-1){1'b0}}, raw_i};
        hit_masked: prdata = {{(BUS_W-1){1'b0}}, raw_i && irq_en_q};
        hit_key:    prdata = {{(BUS_W-1){1'b0}}, lock_q};
        hit_tmode:  prdata = {{(BUS_W-1){1'b0}}, tmode_q};
        default:    prdata = '0;
      endcase
    end
  end

  assign irq_en_o = irq_en_q;
  assign rst_en_o = rst_en_q;
  assign tmode_o  = tmode_q;
  assign tdrive_o = tdrive_q;

  assert_locked_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_access && !hit_key)
      |=> ($stable(irq_en_q) && $stable(rst_en_q) && $stable(tmode_q) && $stable(tdrive_q)));

  assert_no_cmd_when_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> (!cmd_o.reload_wr && !cmd_o.ack_wr));

  assert_key_unlocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_access && hit_key && pwdata == UNLOCK_KEY) |=> !lock_q);

  assert_ro_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_access && !hit_key && !hit_ctrl && !hit_tmode && !hit_tdrive)
      |=> ($stable(irq_en_q) && $stable(rst_en_q) && $stable(tmode_q) && $stable(tdrive_q)));

endmodule

// File: rtl/wdt_out_sel.sv
module wdt_out_sel
  import wdt_pkg::*;
(
  input  logic             tmode,
  input  logic [N_OUT-1:0] func_i,
  input  logic [N_OUT-1:0] tdrive_i,
  output logic [N_OUT-1:0] out_o
);

  for (genvar g = 0; g < N_OUT; g++) begin : g_pin
    assign out_o[g] = tmode ? tdrive_i[g] : func_i[g];
  end

endmodule

// File: rtl/apb_wdt.sv
module apb_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              tick_en,
  output logic              wdt_irq,
  output logic              wdt_rst
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_n;

  // asynchronous assertion, release aligned to pclk
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) rsync_q <= '0;
    else          rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n = rsync_q[SYNC_STAGES-1];

  wdt_cmd_t         cmd;
  logic [CNT_W-1:0] wdata, count, reload;
  logic             raw, rst_stat, irq_en, rst_en, tmode;
  logic [N_OUT-1:0] tdrive, func, pins;

  wdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
    .clk      (pclk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .prdata   (prdata),
    .count_i  (count),
    .reload_i (reload),
    .raw_i    (raw),
    .cmd_o    (cmd),
    .wdata_o  (wdata),
    .irq_en_o (irq_en),
    .rst_en_o (rst_en),
    .tmode_o  (tmode),
    .tdrive_o (tdrive)
  );

  wdt_core #(.CNT_W(CNT_W)) core_i (
    .clk        (pclk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .cmd        (cmd),
    .wdata      (wdata),
    .count_o    (count),
    .reload_o   (reload),
    .raw_o      (raw),
    .rst_stat_o (rst_stat)
  );

  always_comb begin
    func          = '0;
    func[OUT_IRQ] = raw && irq_en;
    func[OUT_RST] = rst_stat && rst_en;
  end

  wdt_out_sel sel_i (
    .tmode    (tmode),
    .func_i   (func),
    .tdrive_i (tdrive),
    .out_o    (pins)
  );

  assign wdt_irq = pins[OUT_IRQ];
  assign wdt_rst = pins[OUT_RST];
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  assert_rst_pin_holds_R4: assert property (@(posedge pclk) disable iff (!rst_n)
    (wdt_rst && !tmode) |=> (wdt_rst || !rst_en || tmode));

  assert_irq_needs_flag_R5: assert property (@(posedge pclk) disable iff (!rst_n)
    (wdt_irq && !tmode) |-> raw);

  assert_test_drive_R9: assert property (@(posedge pclk) disable iff (!rst_n)
    tmode |-> (wdt_irq == tdrive[OUT_IRQ] && wdt_rst == tdrive[OUT_RST]));

endmodule

// File: tb/apb_wdt_tb_top.sv
module apb_wdt_tb_top;

  logic        pclk = 1'b0;
  logic        presetn;
  logic        psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        tick_en;
  logic        wdt_irq, wdt_rst;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 pclk = ~pclk;

  apb_wdt dut_i (
    .pclk    (pclk),
    .presetn (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .prdata  (prdata),
    .pready  (pready),
    .pslverr (pslverr),
    .tick_en (tick_en),
    .wdt_irq (wdt_irq),
    .wdt_rst (wdt_rst)
  );

  localparam logic [11:0] A_RELOAD = 12'h000, A_COUNT = 12'h004, A_CTRL = 12'h008;
  localparam logic [11:0] A_ACK = 12'h00C, A_RAW = 12'h010, A_MASKED = 12'h014;
  localparam logic [11:0] A_KEY = 12'hC00, A_TMODE = 12'hF00, A_TDRIVE = 12'hF04;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge pclk);
    presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; tick_en = 1'b0;
    repeat (2) @(negedge pclk);
    presetn = 1'b1;
    repeat (3) @(negedge pclk);
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge pclk);
    tick_en = 1'b1;
    repeat (n) @(negedge pclk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    apb_rd(A_RELOAD, d); chk("R1 reload", d, 32'hFFFF_FFFF);
    apb_rd(A_COUNT, d);  chk("R1 count", d, 32'hFFFF_FFFF);
    apb_rd(A_CTRL, d);   chk("R1 ctrl", d, 0);
    apb_rd(A_RAW, d);    chk("R1 raw", d, 0);
    apb_rd(A_KEY, d);    chk("R1 lock", d, 0);
    apb_rd(A_TMODE, d);  chk("R1 tmode", d, 0);
    chk("R1 pins", {30'b0, wdt_irq, wdt_rst}, 0);
    ticks(4);
    apb_rd(A_COUNT, d);  chk("R1 running", d, 32'hFFFF_FFFB);
  endtask

  task automatic t_count_and_first_timeout();
    logic [31:0] d;
    do_reset();
    apb_wr(A_RELOAD, 10);
    apb_rd(A_COUNT, d); chk("R6 count after load", d, 10);
    ticks(3);
    apb_rd(A_COUNT, d); chk("R2 after 3 ticks", d, 7);
    repeat (5) @(negedge pclk);
    apb_rd(A_COUNT, d); chk("R2 hold without tick", d, 7);
    apb_wr(A_CTRL, 32'h1);
    ticks(7);
    apb_rd(A_COUNT, d); chk("R2 reached zero", d, 0);
    chk("R3 no irq yet", {31'b0, wdt_irq}, 0);
    ticks(1);
    apb_rd(A_RAW, d);   chk("R3 raw set", d, 1);
    apb_rd(A_COUNT, d); chk("R3 reloaded", d, 10);
    chk("R5 irq high", {31'b0, wdt_irq}, 1);
    apb_rd(A_MASKED, d); chk("R5 masked on", d, 1);
    apb_wr(A_CTRL, 32'h0);
    chk("R5 irq masked", {31'b0, wdt_irq}, 0);
    apb_rd(A_MASKED, d); chk("R5 masked off", d, 0);
    apb_rd(A_RAW, d);    chk("R5 raw kept", d, 1);
    ticks(4);
    apb_wr(A_ACK, 32'hDEAD);
    apb_rd(A_RAW, d);   chk("R7 raw cleared", d, 0);
    apb_rd(A_COUNT, d); chk("R7 count reloaded", d, 10);
  endtask

  task automatic t_second_timeout();
    logic [31:0] d;
    do_reset();
    apb_wr(A_CTRL, 32'h3);
    apb_wr(A_RELOAD, 2);
    ticks(3);
    chk("R3 irq first stage", {31'b0, wdt_irq}, 1);
    chk("R4 no reset yet", {31'b0, wdt_rst}, 0);
    ticks(3);
    chk("R4 reset asserted", {31'b0, wdt_rst}, 1);
    ticks(5);
    apb_rd(A_COUNT, d); chk("R4 counter stopped", d, 0);
    apb_wr(A_CTRL, 32'h1);
    chk("R5 reset masked", {31'b0, wdt_rst}, 0);
    apb_wr(A_CTRL, 32'h3);
    chk("R4 sticky reset", {31'b0, wdt_rst}, 1);
    apb_wr(A_ACK, 0);
    chk("R7 ack keeps reset", {31'b0, wdt_rst}, 1);
    ticks(2);
    apb_rd(A_COUNT, d); chk("R4 still stopped", d, 2);
    apb_wr(A_RELOAD, 5);
    ticks(1);
    apb_rd(A_COUNT, d); chk("R6 restarted", d, 4);
    chk("R4 reset after restart", {31'b0, wdt_rst}, 1);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    do_reset();
    apb_wr(A_KEY, 32'h1234);
    apb_rd(A_KEY, d); chk("R8 locked", d, 1);
    apb_wr(A_RELOAD, 32'h55);
    apb_rd(A_RELOAD, d); chk("R8 reload ignored", d, 32'hFFFF_FFFF);
    apb_wr(A_CTRL, 32'h3);
    apb_rd(A_CTRL, d); chk("R8 ctrl ignored", d, 0);
    apb_wr(A_KEY, KEY);
    apb_rd(A_KEY, d); chk("R8 unlocked", d, 0);
    apb_wr(A_RELOAD, 32'h55);
    apb_rd(A_RELOAD, d); chk("R8 write after unlock", d, 32'h55);
  endtask

  task automatic t_test_mode();
    logic [31:0] d;
    do_reset();
    apb_wr(A_TMODE, 1);
    apb_wr(A_TDRIVE, 32'h2);
    chk("R9 irq driven", {30'b0, wdt_irq, wdt_rst}, 32'h2);
    apb_wr(A_TDRIVE, 32'h1);
    chk("R9 rst driven", {30'b0, wdt_irq, wdt_rst}, 32'h1);
    apb_rd(A_TMODE, d);  chk("R9 tmode reads", d, 1);
    apb_rd(A_TDRIVE, d); chk("R10 wo reads zero", d, 0);
    apb_wr(A_TMODE, 0);
    chk("R9 back to functional", {30'b0, wdt_irq, wdt_rst}, 0);
  endtask

  task automatic t_map_edges();
    logic [31:0] d;
    do_reset();
    apb_wr(A_RELOAD, 20);
    apb_wr(A_COUNT, 3);
    apb_wr(A_RAW, 1);
    apb_wr(A_MASKED, 1);
    apb_wr(12'h100, 32'hFFFF_FFFF);
    apb_rd(A_COUNT, d);  chk("R10 count write ignored", d, 20);
    apb_rd(A_RAW, d);    chk("R10 raw write ignored", d, 0);
    apb_rd(A_RELOAD, d); chk("R10 unmapped write ignored", d, 20);
    apb_rd(A_ACK, d);    chk("R10 ack reads zero", d, 0);
    apb_rd(12'h200, d);  chk("R10 unmapped reads zero", d, 0);
    chk("R10 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
    apb_wr(A_CTRL, 32'hFFFF_FFFF);
    apb_rd(A_CTRL, d); chk("R5 ctrl upper bits", d, 3);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    do_reset();
    apb_wr(A_RELOAD, 100);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = A_RELOAD; pwdata = 40; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1; tick_en = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; tick_en = 1'b0;
    apb_rd(A_COUNT, d); chk("R11 write beats tick", d, 40);
  endtask

  initial begin
    #(2_000_000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; tick_en = 1'b0;
    t_reset_state();
    t_count_and_first_timeout();
    t_second_timeout();
    t_lock();
    t_test_mode();
    t_map_edges();
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule